// File: doc/BRIEF.md
# Eight-Instruction Accumulator Processor

A small unpipelined processor with one shared memory for program and data. It holds an accumulator, a second operand register that also serves as a store address, a program counter and a one-bit carry flag. One adder does the arithmetic. A second adder, fed with the constant one, advances the program counter. A multi-state controller steps through fetch, execute, store and halt.

Each fetched byte carries its operation in its three most significant bits. The two-word forms (loads, store, jumps) take their operand from the byte that follows. The accumulator is the only value that can be written to memory. Subtraction has no inverter in the arithmetic path: software keeps the subtrahend in the operand register already complemented, and the processor adds it with the carry input forced high.

The memory sits outside the block. It answers reads combinationally from the address the block drives and takes a write on the rising edge while the write strobe is high.

Top module: `accum_cpu`

## Requirements
- R1: Synchronous active-high reset clears the program counter, accumulator, operand register and carry flag. During reset and in the first cycle after it, mem_addr is 0, mem_we is 0 and halted is 0.
- R2: The operation is taken from bits [7:5] of the fetched byte, and bits [4:0] have no effect. The codes are: 000 add, 001 subtract, 010 load accumulator, 011 load operand register, 100 store, 101 jump, 110 jump on carry, 111 halt.
- R3: Add (000) takes 2 cycles. It sets the accumulator to accumulator + operand register, modulo 256, captures the carry-out in the flag, and advances the program counter by 1.
- R4: Subtract (001) takes 2 cycles. It sets the accumulator to accumulator + operand register + 1, modulo 256, captures the carry-out in the flag, and advances the program counter by 1.
- R5: Load accumulator (010) and load operand register (011) each take 2 cycles. Each copies the following memory byte into its register and advances the program counter by 2.
- R6: Store (100) takes 3 cycles. It copies the following byte into the operand register and advances the program counter by 2. In its third cycle it drives the operand register on mem_addr, the accumulator on mem_wdata and mem_we high, for exactly one cycle.
- R7: Jump (101) takes 2 cycles and loads the program counter from the following byte.
- R8: Jump on carry (110) takes 2 cycles. It loads the program counter from the following byte when the flag is 1. When the flag is 0 it skips the operand, advancing the program counter by 2.
- R9: Halt (111) takes 1 cycle. After it, halted stays high, mem_addr holds the address of the halt byte and no further byte is executed until reset.
- R10: mem_we is high only in the third cycle of a store and is never high while halted.
- R11: The program load accumulator 10, load operand register 5, add, store to 8, halt writes 15 to address 8 and reaches the halted state 10 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address: program counter, or operand register during a store |
| mem_rdata | input | 8 | Byte read combinationally from mem_addr |
| mem_wdata | output | 8 | Accumulator value to be written |
| mem_we | output | 1 | Active-high write strobe |
| halted | output | 1 | High once a halt byte has been executed |

## Verification
Every instruction's effect is registered on the last edge of its 2- or 3-cycle window, so each program's completion is counted in rising edges from the release of reset: the halted flag must appear exactly at the summed cycle count of the program, with the halt adding one edge. Results are checked at negative edges. Memory results are read from the bench's memory model once halted is seen. The final mem_addr shows where execution stopped, which exposes which way a conditional jump went. A write counter catches any stray strobe, and extra cycles after halting confirm that nothing moves.

// File: rtl/acp_pkg.sv
package acp_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_LDA  = 3'b010,
    OP_LDB  = 3'b011,
    OP_STR  = 3'b100,
    OP_JMP  = 3'b101,
    OP_JOV  = 3'b110,
    OP_HALT = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {
    S_FETCH = 2'd0,
    S_EXEC  = 2'd1,
    S_STORE = 2'd2,
    S_HALT  = 2'd3
  } state_e;

  // Datapath steering produced by the controller each cycle
  typedef struct packed {
    logic a_from_ext;   // accumulator source: 1 = memory byte, 0 = adder
    logic pc_from_ext;  // PC source: 1 = memory byte, 0 = incrementer
    logic addr_from_b;  // address source: 1 = operand register, 0 = PC
    logic ld_a;
    logic ld_b;
    logic ld_pc;
    logic ld_flag;
    logic carry_in;
  } ctl_t;

endpackage

// File: rtl/acp_adder.sv
module acp_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH:0] wide;

  always_comb begin
    wide = {1'b0, op_x} + {1'b0, op_y} + {{WIDTH{1'b0}}, cin};
    sum  = wide[WIDTH-1:0];
    cout = wide[WIDTH];
  end
endmodule

// File: rtl/acp_ctrl.sv
module acp_ctrl
  import acp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e opc_in,
  input  logic    flag,
  output ctl_t    ctl,
  output logic    mem_we,
  output logic    halted
);
  state_e  state, nxt;
  opcode_e ir;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      ir    <= OP_ADD;
    end else begin
      state <= nxt;
      if (state == S_FETCH) ir <= opc_in;
    end
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      S_FETCH: begin
        if (opc_in == OP_HALT) begin
          nxt = S_HALT;               // PC stays on the halt byte
        end else begin
          ctl.ld_pc = 1'b1;
          nxt = S_EXEC;
        end
      end
      S_EXEC: begin
        nxt = S_FETCH;
        case (ir)
          OP_ADD, OP_SUB: begin
            ctl.ld_a     = 1'b1;
            ctl.ld_flag  = 1'b1;
            ctl.carry_in = (ir == OP_SUB);
          end
          OP_LDA: begin
            ctl.a_from_ext = 1'b1;
            ctl.ld_a       = 1'b1;
            ctl.ld_pc      = 1'b1;
          end
          OP_LDB: begin
            ctl.ld_b  = 1'b1;
            ctl.ld_pc = 1'b1;
          end
          OP_STR: begin
            ctl.ld_b  = 1'b1;
            ctl.ld_pc = 1'b1;
            nxt       = S_STORE;
          end
          OP_JMP: begin
            ctl.pc_from_ext = 1'b1;
            ctl.ld_pc       = 1'b1;
          end
          OP_JOV: begin
            ctl.pc_from_ext = flag;
            ctl.ld_pc       = 1'b1;
          end
          default: nxt = S_HALT;
        endcase
      end
      S_STORE: begin
        ctl.addr_from_b = 1'b1;
        nxt = S_FETCH;
      end
      default: nxt = S_HALT;
    endcase
  end

  assign mem_we = (state == S_STORE);
  assign halted = (state == S_HALT);
endmodule

// File: rtl/acp_datapath.sv
module acp_datapath
  import acp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl,
  input  logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] addr,
  output logic [WIDTH-1:0] wdata,
  output logic             flag
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] acc, opb, pc;
  logic [WIDTH-1:0] alu_sum, pc_next;
  logic             alu_cout, inc_cout;

  acp_adder #(.WIDTH(WIDTH)) u_alu (
    .op_x(acc), .op_y(opb), .cin(ctl.carry_in), .sum(alu_sum), .cout(alu_cout)
  );

  acp_adder #(.WIDTH(WIDTH)) u_inc (
    .op_x(pc), .op_y(ONE), .cin(1'b0), .sum(pc_next), .cout(inc_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      opb  <= '0;
      pc   <= '0;
      flag <= 1'b0;
    end else begin
      if (ctl.ld_a)    acc  <= ctl.a_from_ext  ? rdata : alu_sum;
      if (ctl.ld_b)    opb  <= rdata;
      if (ctl.ld_pc)   pc   <= ctl.pc_from_ext ? rdata : pc_next;
      if (ctl.ld_flag) flag <= alu_cout;
    end
  end

  assign addr  = ctl.addr_from_b ? opb : pc;
  assign wdata = acc;
endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
  import acp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] mem_addr,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic [WIDTH-1:0] mem_wdata,
  output logic             mem_we,
  output logic             halted
);
  localparam int OPC_LSB = WIDTH - 3;

  ctl_t    ctl;
  logic    flag;
  opcode_e opc;

  assign opc = opcode_e'(mem_rdata[WIDTH-1:OPC_LSB]);

  acp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opc_in(opc), .flag(flag),
    .ctl(ctl), .mem_we(mem_we), .halted(halted)
  );

  acp_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .rdata(mem_rdata),
    .addr(mem_addr), .wdata(mem_wdata), .flag(flag)
  );
endmodule

// File: rtl/acp_checker.sv
module acp_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] mem_addr,
  input logic [WIDTH-1:0] mem_rdata,
  input logic             mem_we,
  input logic             halted
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == '0 && !mem_we && !halted)); // R1

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(mem_addr))); // R9

  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we); // R10

  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R6

  AST_STORE_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr == $past(mem_rdata)); // R6
endmodule

bind accum_cpu acp_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
  .mem_we(mem_we), .halted(halted)
);

// File: tb/sim_accum_cpu.sv
`timescale 1ns/1ps
module sim_accum_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mem_addr, mem_rdata, mem_wdata;
  logic       mem_we, halted;
  logic [7:0] mem [256];
  int         wr_cnt = 0;
  int         n_chk = 0, n_err = 0, cyc_total = 0;

  always #2.5 clk = ~clk;

  accum_cpu u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 150000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc_total);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wr_cnt = 0;
  endtask

  // Reset, check the reset state (R1), then count edges until halted
  task automatic run(output int cycles);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", mem_addr, 0);
    chk("R1 we/halt in reset", {mem_we, halted}, 0);
    rst = 1'b0;
    cycles = 0;
    do begin
      @(posedge clk); cycles++;
      @(negedge clk);
      if (cycles == 1 && !halted) chk("R1 first fetch advanced", mem_addr, 1);
    end while (!halted && cycles < 200);
  endtask

  task automatic t_example(); // R11, R3, R5, R6
    int c;
    clear_mem();
    mem[0] = 8'h40; mem[1] = 8'd10; mem[2] = 8'h60; mem[3] = 8'd5;
    mem[4] = 8'h00; mem[5] = 8'h80; mem[6] = 8'd8;  mem[7] = 8'hE0;
    run(c);
    chk("R11 mem[8]", mem[8], 15);
    chk("R11 cycles to halt", c, 10);
    chk("R9 halt addr", mem_addr, 7);
    chk("R10 write count", wr_cnt, 1);
  endtask

  task automatic t_carry_taken(); // R3, R8
    int c;
    clear_mem();
    mem[0] = 8'h40; mem[1] = 8'd200; mem[2] = 8'h60; mem[3] = 8'd100;
    mem[4] = 8'h00; mem[5] = 8'h80; mem[6] = 8'd240;
    mem[7] = 8'hC0; mem[8] = 8'd12; mem[9] = 8'hE0; mem[12] = 8'hE0;
    run(c);
    chk("R3 add wraps", mem[240], 44);
    chk("R8 taken halt addr", mem_addr, 12);
    chk("R8 taken cycles", c, 12);
  endtask

  task automatic t_not_taken(); // R8, R5
    int c;
    clear_mem();
    mem[0] = 8'h40; mem[1] = 8'd1; mem[2] = 8'h60; mem[3] = 8'd2;
    mem[4] = 8'h00; mem[5] = 8'hC0; mem[6] = 8'd20;
    mem[7] = 8'h80; mem[8] = 8'd244; mem[9] = 8'hE0; mem[20] = 8'hE0;
    run(c);
    chk("R8 not taken store", mem[244], 3);
    chk("R8 not taken halt addr", mem_addr, 9);
    chk("R8 not taken cycles", c, 12);
  endtask

  task automatic t_sub_lowbits(); // R4, R2
    int c;
    clear_mem();
    mem[0] = 8'h5F; mem[1] = 8'd20; mem[2] = 8'h7A; mem[3] = 8'd205;
    mem[4] = 8'h3F; mem[5] = 8'h9F; mem[6] = 8'd242; mem[7] = 8'hFF;
    run(c);
    chk("R4 subtract 20-50", mem[242], 226);
    chk("R2 low bits ignored cycles", c, 10);
    chk("R2 halt with low bits addr", mem_addr, 7);
  endtask

  task automatic t_jump_halt(); // R7, R9, R10
    int c;
    clear_mem();
    mem[0] = 8'hA0; mem[1] = 8'd10; mem[2] = 8'h80; mem[3] = 8'd250;
    mem[10] = 8'h40; mem[11] = 8'd77; mem[12] = 8'h80; mem[13] = 8'd243;
    mem[14] = 8'hE0;
    run(c);
    chk("R7 jump target store", mem[243], 77);
    chk("R7 skipped store", mem[250], 0);
    chk("R7 cycles", c, 8);
    repeat (20) @(negedge clk);
    chk("R9 still halted", halted, 1);
    chk("R9 addr held", mem_addr, 14);
    chk("R10 no writes while halted", wr_cnt, 1);
  endtask

  initial begin
    t_example();
    t_carry_taken();
    t_not_taken();
    t_sub_lowbits();
    t_jump_halt();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule